// File: doc/BRIEF.md
# Phase/Frequency Comparator with Pump Control

This block compares two single-cycle strobes, one from the reference divider and one from the feedback divider, and turns the timing between them into control for an external charge pump: a source enable (`pump_up`), a sink enable (`pump_dn`) and an output enable (`pump_oe`). When the output enable is low, the pump pin is taken to be high-impedance. The comparator keeps one state bit per input. A strobe on one side holds its enable until the other side's strobe arrives. Once both are present, both enables stay high together for a fixed number of cycles and then clear. Because of this hold, phase differences beyond one period are tracked, and the block also acts as a frequency detector. The overlap window keeps pulses alive at lock, so there is no dead zone.

Configuration inputs select the polarity of the controlled oscillator, force the pump to high-impedance, or route one divider output straight onto the pump pin for test. Power-down comes from three sources. The chip-enable pin and the immediate power-down request act in the same cycle and discard any pulse in progress. The deferred power-down request waits until the running pump pulse has finished. While powered down, the comparator is held empty, so the first strobes after power-up start from a clean state.

Top module: `pfd_cp_ctrl`

## Requirements
- R1: After reset, with `chip_en`=1 and every other control input 0, the outputs are `pump_up`=0, `pump_dn`=0, `pump_oe`=1.
- R2: Run mode, `pol_pos`=1, `MIN_W`=2. A strobe on one input raises that input's enable (reference gives `pump_up`, feedback gives `pump_dn`) in the cycle after the strobe. Once the other strobe has also been registered, both enables stay high for exactly `MIN_W` cycles and then both fall in the same cycle.
- R3: When both strobes arrive in the same cycle, `pump_up` and `pump_dn` are both high for exactly `MIN_W` cycles. Neither is high for longer.
- R4: With `pol_pos`=0, the roles of `pump_up` and `pump_dn` are exchanged: a leading reference strobe drives `pump_dn`.
- R5: With `cp_hiz`=1 and `test_route`=0, `pump_oe`=0 and both enables are 0 in that same cycle. Strobes that arrive during this time are ignored and leave no state behind once `cp_hiz` returns to 0.
- R6: With `test_route`=1 and power enabled, `pump_oe`=1 and `pump_up` carries the selected divider level, with `pump_dn` its inverse. The selected level is `fb_lvl` when `pol_pos`=1 and `ref_lvl` when `pol_pos`=0.
- R7: `chip_en`=0 or `pd_async`=1 forces `pump_oe`=0 and both enables to 0 in the same cycle, overriding every other mode. Any pulse in progress is discarded.
- R8: `pd_sync`=1 does not cut a running pulse short. `pump_oe` falls one cycle after the comparator holds no pulse and no strobe is present. While powered down this way, strobes are ignored. `pump_oe` returns one cycle after `pd_sync` falls.
- R9: Repeated reference strobes with no feedback strobe keep `pump_up` high without interruption (frequency-detector behaviour).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_stb | input | 1 | Single-cycle strobe from the reference divider |
| fb_stb | input | 1 | Single-cycle strobe from the feedback divider |
| ref_lvl | input | 1 | Reference divider output level, used for test routing |
| fb_lvl | input | 1 | Feedback divider output level, used for test routing |
| pol_pos | input | 1 | 1: positive oscillator slope, 0: negative (swaps up/down) |
| cp_hiz | input | 1 | Force pump output to high-impedance |
| test_route | input | 1 | Route a divider level onto the pump pin |
| chip_en | input | 1 | Chip enable; 0 powers down at once |
| pd_async | input | 1 | Immediate power-down request |
| pd_sync | input | 1 | Deferred power-down request, effective after the pulse ends |
| pump_up | output | 1 | Pump source enable |
| pump_dn | output | 1 | Pump sink enable |
| pump_oe | output | 1 | Pump output enable (0 = high-impedance) |

## Verification
The collision that matters is a deferred power-down request arriving while a pump pulse is running. Either function could claim that cycle: the pulse logic wants to keep the pump driven, and the power-down logic wants to release it. The bench opens a pulse with a lone reference strobe, raises `pd_sync` on the next cycle, and holds it across the rest of the pulse and its closing overlap window. It then checks that `pump_oe` stays high until the cycle after both enables have fallen, that a strobe arriving while powered down leaves no trace, and, for contrast, that `pd_async` raised in the middle of a pulse kills the pulse in the same cycle.

// File: rtl/pfd_cp_pkg.sv
package pfd_cp_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_HIZ  = 2'd1,
      PM_TEST = 2'd2,
      PM_OFF  = 2'd3
   } pump_mode_e;
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter int MIN_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ref_stb,
   input  logic fb_stb,
   output logic ref_seen,
   output logic fb_seen
);
   logic both;
   logic done;

   assign both = ref_seen & fb_seen;

   if (MIN_W < 1) begin : g_bad_width
      $error("pfd_core: MIN_W must be at least 1");
   end

   if (MIN_W == 1) begin : g_no_cnt
      assign done = both;
   end else begin : g_cnt
      localparam int CNT_W = $clog2(MIN_W);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_W - 1);
      logic [CNT_W-1:0] ovl_cnt;

      assign done = both & (ovl_cnt == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ovl_cnt <= '0;
         end else if (!run || !both || done) begin
            ovl_cnt <= '0;
         end else begin
            ovl_cnt <= ovl_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_seen <= 1'b0;
         fb_seen  <= 1'b0;
      end else if (!run) begin
         ref_seen <= 1'b0;
         fb_seen  <= 1'b0;
      end else begin
         if (ref_stb)   ref_seen <= 1'b1;
         else if (done) ref_seen <= 1'b0;
         if (fb_stb)    fb_seen  <= 1'b1;
         else if (done) fb_seen  <= 1'b0;
      end
   end
endmodule

// File: rtl/pfd_pd_ctrl.sv
module pfd_pd_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_sync,
   input  logic busy,
   output logic sync_off
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_off <= 1'b0;
      end else if (!pd_sync) begin
         sync_off <= 1'b0;
      end else if (!busy) begin
         sync_off <= 1'b1;
      end
   end
endmodule

// File: rtl/pfd_out_mux.sv
module pfd_out_mux
   import pfd_cp_pkg::*;
(
   input  pump_mode_e mode,
   input  logic       ref_seen,
   input  logic       fb_seen,
   input  logic       pol_pos,
   input  logic       ref_lvl,
   input  logic       fb_lvl,
   output logic       pump_up,
   output logic       pump_dn,
   output logic       pump_oe
);
   logic sel_lvl;

   assign sel_lvl = pol_pos ? fb_lvl : ref_lvl;

   always_comb begin
      pump_up = 1'b0;
      pump_dn = 1'b0;
      pump_oe = 1'b0;
      unique case (mode)
         PM_RUN: begin
            pump_oe = 1'b1;
            pump_up = pol_pos ? ref_seen : fb_seen;
            pump_dn = pol_pos ? fb_seen  : ref_seen;
         end
         PM_TEST: begin
            pump_oe = 1'b1;
            pump_up = sel_lvl;
            pump_dn = ~sel_lvl;
         end
         default: begin
            pump_oe = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/pfd_cp_ctrl.sv
module pfd_cp_ctrl
   import pfd_cp_pkg::*;
#(
   parameter int MIN_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_stb,
   input  logic fb_stb,
   input  logic ref_lvl,
   input  logic fb_lvl,
   input  logic pol_pos,
   input  logic cp_hiz,
   input  logic test_route,
   input  logic chip_en,
   input  logic pd_async,
   input  logic pd_sync,
   output logic pump_up,
   output logic pump_dn,
   output logic pump_oe
);
   pump_mode_e mode;
   logic       ref_seen;
   logic       fb_seen;
   logic       sync_off;
   logic       busy;
   logic       run;

   if (MIN_W > 1024) begin : g_bad_max
      $error("pfd_cp_ctrl: MIN_W out of range");
   end

   always_comb begin
      if (!chip_en || pd_async || sync_off) mode = PM_OFF;
      else if (test_route)                  mode = PM_TEST;
      else if (cp_hiz)                      mode = PM_HIZ;
      else                                  mode = PM_RUN;
   end

   assign run  = (mode == PM_RUN);
   assign busy = ref_seen | fb_seen | ref_stb | fb_stb;

   pfd_core #(.MIN_W(MIN_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .ref_stb  (ref_stb),
      .fb_stb   (fb_stb),
      .ref_seen (ref_seen),
      .fb_seen  (fb_seen)
   );

   pfd_pd_ctrl u_pd (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd_sync  (pd_sync),
      .busy     (busy),
      .sync_off (sync_off)
   );

   pfd_out_mux u_mux (
      .mode     (mode),
      .ref_seen (ref_seen),
      .fb_seen  (fb_seen),
      .pol_pos  (pol_pos),
      .ref_lvl  (ref_lvl),
      .fb_lvl   (fb_lvl),
      .pump_up  (pump_up),
      .pump_dn  (pump_dn),
      .pump_oe  (pump_oe)
   );
endmodule

// File: rtl/pfd_cp_ctrl_chk.sv
module pfd_cp_ctrl_chk #(
   parameter int MIN_W = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cp_hiz,
   input logic test_route,
   input logic chip_en,
   input logic pd_async,
   input logic pump_up,
   input logic pump_dn,
   input logic pump_oe
);
   int unsigned both_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) both_run <= 0;
      else if (pump_oe && !test_route && pump_up && pump_dn) both_run <= both_run + 1;
      else both_run <= 0;
   end

   // R7
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en || pd_async) |-> (!pump_oe && !pump_up && !pump_dn));

   // R5
   hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_hiz && !test_route) |-> (!pump_oe && !pump_up && !pump_dn));

   // R6
   test_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_route && pump_oe) |-> (pump_dn == !pump_up));

   // R3
   overlap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      both_run <= MIN_W);

   // R8
   sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pump_oe && !test_route && (pump_up || pump_dn))
      |=> (!chip_en || pd_async || cp_hiz || test_route || pump_oe));
endmodule

bind pfd_cp_ctrl pfd_cp_ctrl_chk #(.MIN_W(MIN_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cp_hiz     (cp_hiz),
   .test_route (test_route),
   .chip_en    (chip_en),
   .pd_async   (pd_async),
   .pump_up    (pump_up),
   .pump_dn    (pump_dn),
   .pump_oe    (pump_oe)
);

// File: tb/pfd_cp_ctrl_bench.sv
`timescale 1ns/1ps
module pfd_cp_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_stb = 0, fb_stb = 0, ref_lvl = 0, fb_lvl = 0;
   logic pol_pos = 1, cp_hiz = 0, test_route = 0, chip_en = 1, pd_async = 0, pd_sync = 0;
   logic pump_up, pump_dn, pump_oe;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   always #2 clk = ~clk;

   pfd_cp_ctrl #(.MIN_W(2)) u_pfd_cp_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
      .ref_lvl(ref_lvl), .fb_lvl(fb_lvl), .pol_pos(pol_pos), .cp_hiz(cp_hiz),
      .test_route(test_route), .chip_en(chip_en), .pd_async(pd_async),
      .pd_sync(pd_sync), .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe)
   );

   // {ref,fb,pol,hiz,test,rlvl,flvl,ce,apd,spd, exp_up,exp_dn,exp_oe}
   localparam int NV = 34;
   localparam logic [12:0] VEC [NV] = '{
      13'b1_0_1_0_0_0_0_1_0_0_0_0_1, // 0  R2 ref leads
      13'b0_0_1_0_0_0_0_1_0_0_1_0_1, // 1  R2
      13'b1_0_1_0_0_0_0_1_0_0_1_0_1, // 2  R9 second ref
      13'b0_0_1_0_0_0_0_1_0_0_1_0_1, // 3  R9 up held
      13'b0_1_1_0_0_0_0_1_0_0_1_0_1, // 4  R2 fb arrives
      13'b0_0_1_0_0_0_0_1_0_0_1_1_1, // 5  R2 overlap 1
      13'b0_0_1_0_0_0_0_1_0_0_1_1_1, // 6  R2 overlap 2
      13'b0_0_1_0_0_0_0_1_0_0_0_0_1, // 7  R2 cleared
      13'b1_1_1_0_0_0_0_1_0_0_0_0_1, // 8  R3 simultaneous
      13'b0_0_1_0_0_0_0_1_0_0_1_1_1, // 9  R3
      13'b0_0_1_0_0_0_0_1_0_0_1_1_1, // 10 R3
      13'b0_0_1_0_0_0_0_1_0_0_0_0_1, // 11 R3 min pulse ends
      13'b0_1_1_0_0_0_0_1_0_0_0_0_1, // 12 R2 fb leads
      13'b0_0_1_0_0_0_0_1_0_0_0_1_1, // 13 R2
      13'b1_0_1_0_0_0_0_1_0_0_0_1_1, // 14 R2
      13'b0_0_1_0_0_0_0_1_0_0_1_1_1, // 15 R2
      13'b0_0_1_0_0_0_0_1_0_0_1_1_1, // 16 R2
      13'b0_0_1_0_0_0_0_1_0_0_0_0_1, // 17 R2
      13'b1_0_0_0_0_0_0_1_0_0_0_0_1, // 18 R4 negative slope
      13'b0_0_0_0_0_0_0_1_0_0_0_1_1, // 19 R4 ref drives dn
      13'b0_1_0_0_0_0_0_1_0_0_0_1_1, // 20 R4
      13'b0_0_0_0_0_0_0_1_0_0_1_1_1, // 21 R4
      13'b0_0_0_0_0_0_0_1_0_0_1_1_1, // 22 R4
      13'b0_0_0_0_0_0_0_1_0_0_0_0_1, // 23 R4
      13'b1_0_1_1_0_0_0_1_0_0_0_0_0, // 24 R5 hiz, strobe offered
      13'b0_0_1_1_0_0_0_1_0_0_0_0_0, // 25 R5
      13'b0_0_1_0_0_0_0_1_0_0_0_0_1, // 26 R5 strobe left no state
      13'b0_0_1_1_1_1_0_1_0_0_0_1_1, // 27 R6 fb level 0
      13'b0_0_0_1_1_1_0_1_0_0_1_0_1, // 28 R6 ref level 1
      13'b0_0_0_1_1_0_1_1_0_0_0_1_1, // 29 R6 ref level 0
      13'b0_0_1_1_1_0_1_1_0_0_1_0_1, // 30 R6 fb level 1
      13'b0_0_1_1_1_0_1_0_0_0_0_0_0, // 31 R7 chip enable low
      13'b0_0_1_0_0_0_0_1_1_0_0_0_0, // 32 R7 async request
      13'b0_0_1_0_0_0_0_1_0_0_0_0_1  // 33 R7 released
   };
   localparam int VREQ [NV] = '{2,2,9,9,2,2,2,2,3,3,3,3,2,2,2,2,2,2,
                                4,4,4,4,4,4,5,5,5,6,6,6,6,7,7,7};

   task automatic expect3(input logic eu, input logic ed, input logic eo, input string tag);
      n_chk++;
      if (pump_up !== eu || pump_dn !== ed || pump_oe !== eo) begin
         n_bad++;
         $display("FAIL %s: up/dn/oe got %b%b%b expected %b%b%b",
                  tag, pump_up, pump_dn, pump_oe, eu, ed, eo);
      end
   endtask

   task automatic drive(input logic r, input logic f, input logic spd, input logic apd);
      @(negedge clk);
      ref_stb = r; fb_stb = f; pd_sync = spd; pd_async = apd;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      expect3(0, 0, 1, "R1 reset state");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {ref_stb, fb_stb, pol_pos, cp_hiz, test_route, ref_lvl, fb_lvl,
          chip_en, pd_async, pd_sync} = VEC[i][12:3];
         #1;
         n_chk++;
         if ({pump_up, pump_dn, pump_oe} !== VEC[i][2:0]) begin
            n_bad++;
            $display("FAIL vector %0d (R%0d): up/dn/oe got %b%b%b expected %b",
                     i, VREQ[i], pump_up, pump_dn, pump_oe, VEC[i][2:0]);
         end
      end

      // R8: deferred power-down raised mid-pulse
      drive(1, 0, 0, 0); expect3(0, 0, 1, "R8 open pulse");
      drive(0, 0, 1, 0); expect3(1, 0, 1, "R8 request during pulse");
      drive(0, 0, 1, 0); expect3(1, 0, 1, "R8 pulse kept");
      drive(0, 1, 1, 0); expect3(1, 0, 1, "R8 fb strobe");
      drive(0, 0, 1, 0); expect3(1, 1, 1, "R8 overlap 1");
      drive(0, 0, 1, 0); expect3(1, 1, 1, "R8 overlap 2");
      drive(0, 0, 1, 0); expect3(0, 0, 1, "R8 pulse ended, still driven");
      drive(1, 0, 1, 0); expect3(0, 0, 0, "R8 powered down");
      drive(0, 0, 0, 0); expect3(0, 0, 0, "R8 release pending");
      drive(0, 0, 0, 0); expect3(0, 0, 1, "R8 back on, strobe ignored");
      drive(0, 0, 0, 0); expect3(0, 0, 1, "R8 no stale pulse");

      // R7: immediate power-down mid-pulse
      drive(1, 0, 0, 0); expect3(0, 0, 1, "R7 open pulse");
      drive(0, 0, 0, 0); expect3(1, 0, 1, "R7 pulse running");
      drive(0, 0, 0, 1); expect3(0, 0, 0, "R7 same-cycle cut");
      drive(0, 0, 0, 0); expect3(0, 0, 1, "R7 pulse discarded");

      // R9: lone reference strobes, no clear
      drive(1, 0, 0, 0); expect3(0, 0, 1, "R9 first");
      for (int k = 0; k < 4; k++) begin
         drive(k[0], 0, 0, 0); expect3(1, 0, 1, "R9 up held");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got no completion expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule